// File: doc/BRIEF.md
# Dual-Issue Slot Pairing Control

This block sits at the dispatch point of an in-order core. Each cycle it looks at the two oldest decoded instructions, presented on lane 0 (older) and lane 1 (younger). It decides whether both can leave together, only the older one can leave, or nothing can leave. The issue slots form a group aligned to 8 bytes. Slot 0 takes the instruction at the even word and always holds the older one, and slot 1 takes the odd word. The block drives one enable per slot and reports how many lanes it consumed, 0, 1 or 2.

When it consumes one lane, the upstream queue moves lane 1 into lane 0 for the next cycle. When it consumes none, the upstream queue holds both lanes.

A microcoded instruction at the head of lane 0 holds issue while its first micro-operation is fetched from the sequencer ROM. During that time the block shows a busy flag and a count of the cycles left. A stall input freezes the block and blocks all issue.

Top module: `issue_pair_ctl`

## Requirements
- R1: When `stall_i` is high, or lane 0 is not valid, both slot enables are low and `take_o` is 0.
- R2: Both instructions issue together (both enables high, `take_o` = 2) when all of the following hold. Both lanes are valid. Lane 0 is at an even word and lane 1 is at an odd word. No pairing rule below forbids the pair.
- R3: An instruction whose word address is odd (`odd_i[g]` = 1) may only occupy slot 1. If lane 0 is odd, or lane 1 is even, lane 0 issues alone.
- R4: A branch (class code 2) may only occupy slot 1. A branch in lane 0 issues alone in slot 1, even at an even address.
- R5: If the older instruction is non-pipelined (`lead_np_i` = 1), it issues alone. A non-pipelined instruction in lane 1 does not prevent pairing, and the bench relies on that.
- R6: If both lanes access the condition register (`cr_i` = 2'b11), only lane 0 issues.
- R7: The class codes are: fixed-point 0, load/store 1, branch 2, vector arithmetic 3, vector permute/load-store 4. Codes 5 to 7 never pair. Two instructions of the same class never pair. Load/store and vector permute never pair, in either order. All other pairs of classes may pair.
- R8: A context-synchronizing instruction (`csi_i[g]`) in either lane prevents pairing.
- R9: A microcoded instruction (`mc_i[g]`) in either lane prevents pairing. When a microcoded instruction first heads lane 0, nothing issues for `ROM_LAT` unstalled cycles. During that wait `rom_wait_o` is high and `rom_left_o` counts down from `ROM_LAT` to 1. On the next unstalled cycle the instruction issues alone, with `rom_left_o` = 0.
- R10: While `stall_i` is high during a microcode wait, `rom_left_o` and `rom_wait_o` hold their values.
- R11: When only lane 0 issues, exactly one enable is high: slot 1 if lane 0 is odd or a branch, otherwise slot 0. `take_o` always equals the number of enables that are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Freeze; no issue, state held |
| vld_i | input | 2 | Lane valid, bit g for lane g |
| cls_i | input | 6 | Unit class, lane g at bits [3g+2:3g] |
| lead_np_i | input | 1 | Lane 0 instruction is non-pipelined |
| mc_i | input | 2 | Lane is microcoded |
| csi_i | input | 2 | Lane is context-synchronizing |
| cr_i | input | 2 | Lane reads or writes the condition register |
| odd_i | input | 2 | Lane word address is odd (address bit 2) |
| slot0_en_o | output | 1 | Issue into slot 0 |
| slot1_en_o | output | 1 | Issue into slot 1 |
| take_o | output | 2 | Lanes consumed this cycle |
| rom_wait_o | output | 1 | Microcode ROM wait in progress |
| rom_left_o | output | 3 | Wait cycles remaining before the microcoded instruction issues |

## Verification
The countdown and hold properties assume one thing about the upstream queue. Whenever `take_o` is 0 and lane 0 is valid, it presents the same lane 0 contents on the next cycle. Without that, a microcode wait could be abandoned halfway. The stimulus keeps its own model of the two-entry queue and shifts it only by the number of lanes the requirements say were consumed. It therefore holds a waiting microcoded instruction in place through stalls, and stays inside that assumption. It also keeps class codes within 0 to 4, except where the reserved codes are exercised on purpose.

// File: rtl/issue_pair_pkg.sv
package issue_pair_pkg;

  localparam int unsigned CLS_W = 3;
  localparam int unsigned NLANE = 2;

  typedef enum logic [CLS_W-1:0] {
    UC_FX = 3'd0,
    UC_LS = 3'd1,
    UC_BR = 3'd2,
    UC_VA = 3'd3,
    UC_VP = 3'd4
  } ucls_e;

  // true when the two classes may share a dispatch group
  function automatic logic cls_compatible(logic [CLS_W-1:0] a, logic [CLS_W-1:0] b);
    if (a > UC_VP || b > UC_VP) return 1'b0;
    if (a == b) return 1'b0;
    if ((a == UC_LS && b == UC_VP) || (a == UC_VP && b == UC_LS)) return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/issue_lane_dec.sv
module issue_lane_dec
  import issue_pair_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  input  logic             mc_i,
  input  logic             csi_i,
  input  logic             odd_i,
  output logic             solo_o,
  output logic             slot1_only_o
);

  assign solo_o       = mc_i | csi_i;
  assign slot1_only_o = odd_i | (cls_i == UC_BR);

endmodule

// File: rtl/issue_pair_rule.sv
module issue_pair_rule
  import issue_pair_pkg::*;
(
  input  logic [NLANE-1:0] vld_i,
  input  logic [CLS_W-1:0] cls0_i,
  input  logic [CLS_W-1:0] cls1_i,
  input  logic [NLANE-1:0] cr_i,
  input  logic             odd1_i,
  input  logic             lead_np_i,
  input  logic [NLANE-1:0] solo_i,
  input  logic [NLANE-1:0] slot1_only_i,
  output logic             pair_o
);

  logic lead_ok, trail_ok, res_ok;

  // older lane must be able to sit in slot 0 and not block its partner
  assign lead_ok  = vld_i[0] & ~solo_i[0] & ~slot1_only_i[0] & ~lead_np_i;
  assign trail_ok = vld_i[1] & ~solo_i[1] & slot1_only_i[1] & odd1_i;
  assign res_ok   = ~(cr_i[0] & cr_i[1]) & cls_compatible(cls0_i, cls1_i);
  assign pair_o   = lead_ok & trail_ok & res_ok;

endmodule

// File: rtl/issue_rom_wait.sv
module issue_rom_wait #(
  parameter  int unsigned ROM_LAT = 7,
  localparam int unsigned CW      = $clog2(ROM_LAT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stall_i,
  input  logic          head_mc_i,
  output logic          busy_o,
  output logic [CW-1:0] left_o
);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign busy_o = head_mc_i & ~done_q;
  assign left_o = (cnt_q != '0) ? cnt_q : (busy_o ? CW'(ROM_LAT) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!stall_i && head_mc_i) begin
      if (done_q) begin
        done_q <= 1'b0;               // instruction issues this cycle
      end else if (cnt_q == '0) begin
        if (ROM_LAT <= 1) done_q <= 1'b1;
        else              cnt_q  <= CW'(ROM_LAT - 1);
      end else begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/issue_pair_ctl.sv
module issue_pair_ctl
  import issue_pair_pkg::*;
#(
  parameter  int unsigned ROM_LAT = 7,
  localparam int unsigned CW      = $clog2(ROM_LAT + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   stall_i,
  input  logic [NLANE-1:0]       vld_i,
  input  logic [NLANE*CLS_W-1:0] cls_i,
  input  logic                   lead_np_i,
  input  logic [NLANE-1:0]       mc_i,
  input  logic [NLANE-1:0]       csi_i,
  input  logic [NLANE-1:0]       cr_i,
  input  logic [NLANE-1:0]       odd_i,
  output logic                   slot0_en_o,
  output logic                   slot1_en_o,
  output logic [1:0]             take_o,
  output logic                   rom_wait_o,
  output logic [CW-1:0]          rom_left_o
);

  logic [NLANE-1:0] solo, s1_only;
  logic             pair_ok, busy, go, pair, alone;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    issue_lane_dec u_dec (
      .cls_i        (cls_i[CLS_W*g +: CLS_W]),
      .mc_i         (mc_i[g]),
      .csi_i        (csi_i[g]),
      .odd_i        (odd_i[g]),
      .solo_o       (solo[g]),
      .slot1_only_o (s1_only[g])
    );
  end

  issue_pair_rule u_rule (
    .vld_i        (vld_i),
    .cls0_i       (cls_i[CLS_W-1:0]),
    .cls1_i       (cls_i[2*CLS_W-1:CLS_W]),
    .cr_i         (cr_i),
    .odd1_i       (odd_i[1]),
    .lead_np_i    (lead_np_i),
    .solo_i       (solo),
    .slot1_only_i (s1_only),
    .pair_o       (pair_ok)
  );

  issue_rom_wait #(.ROM_LAT(ROM_LAT)) u_rom (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stall_i   (stall_i),
    .head_mc_i (vld_i[0] & mc_i[0]),
    .busy_o    (busy),
    .left_o    (rom_left_o)
  );

  assign go    = vld_i[0] & ~stall_i & ~busy;
  assign pair  = go & pair_ok;
  assign alone = go & ~pair_ok;

  assign slot0_en_o = pair | (alone & ~s1_only[0]);
  assign slot1_en_o = pair | (alone &  s1_only[0]);
  assign take_o     = pair ? 2'd2 : (alone ? 2'd1 : 2'd0);
  assign rom_wait_o = busy;

endmodule

// File: rtl/issue_pair_ctl_chk.sv
module issue_pair_ctl_chk
  import issue_pair_pkg::*;
#(
  parameter  int unsigned ROM_LAT = 7,
  localparam int unsigned CW      = $clog2(ROM_LAT + 1)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   stall_i,
  input logic [NLANE-1:0]       vld_i,
  input logic [NLANE*CLS_W-1:0] cls_i,
  input logic                   lead_np_i,
  input logic [NLANE-1:0]       mc_i,
  input logic [NLANE-1:0]       csi_i,
  input logic [NLANE-1:0]       cr_i,
  input logic [NLANE-1:0]       odd_i,
  input logic                   slot0_en_o,
  input logic                   slot1_en_o,
  input logic [1:0]             take_o,
  input logic                   rom_wait_o,
  input logic [CW-1:0]          rom_left_o
);

  assert_frozen_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> (!slot0_en_o && !slot1_en_o && take_o == 2'd0));

  assert_slot0_even_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot0_en_o |-> !odd_i[0]);

  assert_branch_slot1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot0_en_o |-> (cls_i[CLS_W-1:0] != UC_BR));

  assert_np_lead_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o == 2'd2) |-> !lead_np_i);

  assert_one_cr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o == 2'd2) |-> !(cr_i[0] && cr_i[1]));

  assert_pair_solo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o == 2'd2) |-> (csi_i == '0 && mc_i == '0));

  assert_rom_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && rom_wait_o && rom_left_o > CW'(1)) |=> (rom_left_o == $past(rom_left_o) - CW'(1)));

  assert_rom_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && rom_wait_o && rom_left_o == CW'(1)) |=> (!rom_wait_o && rom_left_o == '0));

  assert_rom_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && rom_wait_o) |=> ($stable(rom_left_o) && rom_wait_o));

  assert_take_count_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o == 2'($countones({slot0_en_o, slot1_en_o})));

endmodule

bind issue_pair_ctl issue_pair_ctl_chk #(.ROM_LAT(ROM_LAT)) u_chk (.*);

// File: tb/test_issue_pair_ctl.sv
module test_issue_pair_ctl;
  localparam int LAT = 7;
  localparam int CW  = $clog2(LAT + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  // lane word: [7] valid, [6:4] class, [3] micro, [2] csi, [1] cr, [0] odd
  logic [7:0] l0 = '0, l1 = '0;
  logic       np0 = 1'b0, stall = 1'b0;

  logic          s0, s1, rw;
  logic [1:0]    take;
  logic [CW-1:0] rl;

  issue_pair_ctl #(.ROM_LAT(LAT)) i_issue_pair_ctl (
    .clk_i(clk), .rst_ni(rst_ni), .stall_i(stall),
    .vld_i({l1[7], l0[7]}), .cls_i({l1[6:4], l0[6:4]}), .lead_np_i(np0),
    .mc_i({l1[3], l0[3]}), .csi_i({l1[2], l0[2]}), .cr_i({l1[1], l0[1]}),
    .odd_i({l1[0], l0[0]}),
    .slot0_en_o(s0), .slot1_en_o(s1), .take_o(take),
    .rom_wait_o(rw), .rom_left_o(rl)
  );

  int n_chk = 0, n_bad = 0, mw = 0;
  logic e_s0, e_s1, e_rw;
  logic [1:0] e_take;
  int e_rl;
  string e_tag;

  function automatic logic [7:0] mk(bit v, int c, bit m, bit cs, bit cr, bit od);
    return {v, 3'(c), m, cs, cr, od};
  endfunction

  function automatic bit cls_ok(int a, int b);
    if (a > 4 || b > 4) return 0;
    if (a == b) return 0;
    if ((a == 1 && b == 4) || (a == 4 && b == 1)) return 0;
    return 1;
  endfunction

  task automatic predict();
    int c0, c1;
    bit single;
    c0 = int'(l0[6:4]); c1 = int'(l1[6:4]);
    e_s0 = 0; e_s1 = 0; e_take = 0; e_rw = 0; e_rl = 0; e_tag = "R1";
    single = 1;
    if (l0[7] && l0[3] && mw < LAT) begin e_rw = 1; e_rl = LAT - mw; end
    if (stall || !l0[7]) begin
      e_tag = e_rw ? "R10" : "R1";
      return;
    end
    if (e_rw) begin e_tag = "R9"; return; end
    if (!l1[7])                     e_tag = "R11";
    else if (l0[3] || l1[3])        e_tag = "R9";
    else if (l0[2] || l1[2])        e_tag = "R8";
    else if (l0[0] || !l1[0])       e_tag = "R3";
    else if (c0 == 2)               e_tag = "R4";
    else if (np0)                   e_tag = "R5";
    else if (l0[1] && l1[1])        e_tag = "R6";
    else if (!cls_ok(c0, c1))       e_tag = "R7";
    else begin e_tag = "R2"; single = 0; end
    if (single) begin
      e_take = 2'd1;
      if (l0[0] || c0 == 2) e_s1 = 1; else e_s0 = 1;
    end else begin
      e_take = 2'd2; e_s0 = 1; e_s1 = 1;
    end
  endtask

  // inputs are already driven; sample 1 ns later, then advance to next negedge
  task automatic step();
    #1;
    predict();
    n_chk++;
    if (s0 !== e_s0 || s1 !== e_s1 || take !== e_take || rw !== e_rw || int'(rl) != e_rl) begin
      n_bad++;
      $display("FAIL %s: got s0=%0b s1=%0b take=%0d wait=%0b left=%0d exp s0=%0b s1=%0b take=%0d wait=%0b left=%0d",
               e_tag, s0, s1, take, rw, rl, e_s0, e_s1, e_take, e_rw, e_rl);
    end
    if (!stall && l0[7] && l0[3]) mw = (e_take != 0) ? 0 : mw + 1;
    @(negedge clk);
  endtask

  task automatic put(bit st, bit np, logic [7:0] a, logic [7:0] b);
    stall = st; np0 = np; l0 = a; l1 = b;
    step();
  endtask

  function automatic logic [7:0] rnd_lane();
    return mk(($urandom % 10) != 0, int'($urandom % 5), ($urandom % 12) == 0,
              ($urandom % 12) == 0, ($urandom % 3) == 0, bit'($urandom % 2));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got no end of run exp end of run");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    step();                                                        // R1 reset state
    put(0, 0, mk(1,0,0,0,0,0), mk(1,1,0,0,0,1));                   // R2 FX+LS
    put(0, 0, mk(1,0,0,0,0,1), mk(1,1,0,0,0,1));                   // R3 odd lead
    put(0, 0, mk(1,0,0,0,0,0), mk(1,1,0,0,0,0));                   // R3 even trail
    put(0, 0, mk(1,2,0,0,0,0), mk(1,0,0,0,0,1));                   // R4 branch lead
    put(0, 0, mk(1,0,0,0,0,0), mk(1,2,0,0,0,1));                   // R4 branch trail pairs
    put(0, 1, mk(1,0,0,0,0,0), mk(1,1,0,0,0,1));                   // R5 np lead
    put(0, 0, mk(1,1,0,0,0,0), mk(1,0,0,0,0,1));                   // R5 np trail pairs
    put(0, 0, mk(1,0,0,0,1,0), mk(1,1,0,0,1,1));                   // R6
    put(0, 0, mk(1,3,0,0,0,0), mk(1,3,0,0,0,1));                   // R7 same class
    put(0, 0, mk(1,1,0,0,0,0), mk(1,4,0,0,0,1));                   // R7 LS+VP
    put(0, 0, mk(1,4,0,0,0,0), mk(1,1,0,0,0,1));                   // R7 VP+LS
    put(0, 0, mk(1,3,0,0,0,0), mk(1,4,0,0,0,1));                   // R7 VA+VP pairs
    put(0, 0, mk(1,6,0,0,0,0), mk(1,0,0,0,0,1));                   // R7 reserved code
    put(0, 0, mk(1,0,0,0,0,0), mk(1,1,0,1,0,1));                   // R8 csi trail
    put(0, 0, mk(1,0,0,1,0,0), mk(1,1,0,0,0,1));                   // R8 csi lead
    put(0, 0, mk(1,0,0,0,0,0), mk(1,1,1,0,0,1));                   // R9 micro trail
    put(1, 0, mk(1,0,0,0,0,0), mk(1,1,0,0,0,1));                   // R1 stall
    put(0, 0, mk(1,0,0,0,0,0), mk(0,1,0,0,0,1));                   // R11 lane1 empty
    put(0, 0, mk(0,0,0,0,0,0), mk(1,1,0,0,0,1));                   // R1 lane0 empty
    // R9/R10 microcode entry with stalls mid-wait
    for (int k = 0; k < 3; k++) put(0, 0, mk(1,0,1,0,0,0), mk(1,1,0,0,0,1));
    for (int k = 0; k < 2; k++) put(1, 0, mk(1,0,1,0,0,0), mk(1,1,0,0,0,1));
    for (int k = 0; k < LAT + 2 && mw != 0; k++) put(0, 0, mk(1,0,1,0,0,0), mk(1,1,0,0,0,1));
    // random stream with a queue model
    l0 = rnd_lane(); l1 = rnd_lane(); l1[0] = ($urandom % 5) != 0;
    for (int n = 0; n < 3000; n++) begin
      stall = ($urandom % 10) == 0;
      np0 = ($urandom % 5) == 0;
      step();
      if (!l0[7] || e_take == 2'd2) begin
        l0 = rnd_lane(); l1 = rnd_lane(); l1[0] = ($urandom % 5) != 0;
        mw = 0;
      end else if (e_take == 2'd1) begin
        l0 = l1; l1 = rnd_lane(); l1[0] = ($urandom % 5) != 0;
      end
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule